// File: doc/BRIEF.md
# Dual-Output Preference-Window Switched-Capacitor Controller

This block sequences one switched-capacitor converter core that feeds two regulated supply rails. A fast input clock is divided into two non-overlapping converter phases separated by a programmable dead time. A control clock toggles once per switching period. Each high half of the control clock is a window in which rail 1 has priority, and each low half is a window in which rail 2 has priority.

Each rail has two comparator inputs, one for each window type. An input reads high when the rail sits below its target. The inputs are synchronised and then sampled once, at the edge that opens a window. That sample decides which rail, if any, owns the window. If the rail with priority does not need its window, the other rail may take it. The owner's switch phases are passed through as true and inverted copies. The shared-switch phases run only when some rail owns the window, so an unclaimed window leaves every switch idle.

Every output is a flop, and a grant can change only at a window boundary. Gating therefore never shortens a phase pulse and never splits a switching period.

Top module: `dual_sc_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all true phase outputs, `ctl_o` and both grants are 0, and all inverted outputs are 1. The first edge after release opens a window with `ctl_o` = 1 and `phi1_o` high.
- R2: Each window lasts 2*(PH_ON+DEAD_CYC) input cycles. Counting from the cycle the window opens, `phi1_o` is high for PH_ON cycles, then both phases are low for DEAD_CYC cycles, then `phi2_o` is high for PH_ON cycles, then both are low for DEAD_CYC cycles. `phi1_o` and `phi2_o` are never high together.
- R3: `ctl_o` inverts at every window opening and is constant within a window.
- R4: Comparator inputs pass through SYNC_STAGES flops. A window's grants come from the synchronised values at the edge that opens it, so a change made one cycle before that edge is not used. Grants stay constant for the whole window.
- R5: In a window with `ctl_o` = 1, `grant1_o` equals the sampled `v1_below_a`. In a window with `ctl_o` = 0, `grant2_o` equals the sampled `v2_below_b`.
- R6: Steal. In a window with `ctl_o` = 1, `grant2_o` = !`v1_below_a` & `v2_below_a`. In a window with `ctl_o` = 0, `grant1_o` = !`v2_below_b` & `v1_below_b`. At most one grant is high.
- R7: `oN_ph1` = `phi1_o` & grantN and `oN_ph2` = `phi2_o` & grantN, in the same cycle, for N = 1 and 2. Each `_n` output is the complement of its true output.
- R8: `sh_ph1` = `o1_ph1` | `o2_ph1` and `sh_ph2` = `o1_ph2` | `o2_ph2`.
- R9: In a window with no grant, all per-rail true outputs and both shared phases stay low for the whole window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| v1_below_a | input | 1 | Rail 1 below target, read for ctl-high windows |
| v1_below_b | input | 1 | Rail 1 below target, read for ctl-low windows |
| v2_below_a | input | 1 | Rail 2 below target, read for ctl-high windows |
| v2_below_b | input | 1 | Rail 2 below target, read for ctl-low windows |
| ctl_o | output | 1 | Control clock: 1 = rail 1 has priority |
| phi1_o | output | 1 | Raw converter phase 1 |
| phi2_o | output | 1 | Raw converter phase 2 |
| grant1_o | output | 1 | Rail 1 owns the current window |
| grant2_o | output | 1 | Rail 2 owns the current window |
| o1_ph1 | output | 1 | Rail 1 phase-1 switch, true |
| o1_ph1_n | output | 1 | Rail 1 phase-1 switch, inverted |
| o1_ph2 | output | 1 | Rail 1 phase-2 switch, true |
| o1_ph2_n | output | 1 | Rail 1 phase-2 switch, inverted |
| o2_ph1 | output | 1 | Rail 2 phase-1 switch, true |
| o2_ph1_n | output | 1 | Rail 2 phase-1 switch, inverted |
| o2_ph2 | output | 1 | Rail 2 phase-2 switch, true |
| o2_ph2_n | output | 1 | Rail 2 phase-2 switch, inverted |
| sh_ph1 | output | 1 | Shared-switch phase 1 |
| sh_ph2 | output | 1 | Shared-switch phase 2 |

## Verification
The bench builds the block with PH_ON=2, DEAD_CYC=2 and SYNC_STAGES=3. This gives an eight-cycle window, so every phase and dead-time slot can be checked cycle by cycle against a fixed template. A dead time of two cycles exercises the programmable gap rather than the minimum of one. The three-stage synchroniser lets a late input change, made one cycle before a window opens, be shown to have no effect on that window's grant. Windows alternate priority, so each comparator combination is applied under both rail-1 and rail-2 priority. This reaches every preference, steal and idle outcome.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
   localparam int unsigned N_RAIL = 2;
   localparam int unsigned RAIL1  = 0;
   localparam int unsigned RAIL2  = 1;

   typedef enum logic {
      PRI_RAIL2 = 1'b0,
      PRI_RAIL1 = 1'b1
   } pri_e;

   typedef logic [N_RAIL-1:0] grant_t;

   // Priority rail wins when it asks. Otherwise the other rail may take the window.
   function automatic grant_t decide(input pri_e pri, input logic req1, input logic req2);
      grant_t g;
      g = '0;
      if (pri == PRI_RAIL1) begin
         g[RAIL1] = req1;
         g[RAIL2] = ~req1 & req2;
      end else begin
         g[RAIL2] = req2;
         g[RAIL1] = ~req2 & req1;
      end
      return g;
   endfunction
endpackage

// File: rtl/dsc_phase_gen.sv
module dsc_phase_gen #(
   parameter int unsigned PH_ON    = 3,
   parameter int unsigned DEAD_CYC = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic wrap_n,
   output logic ctl_n,
   output logic phi1_n,
   output logic phi2_n,
   output logic ctl_q,
   output logic phi1_q,
   output logic phi2_q
);
   localparam int unsigned PERIOD = 2 * (PH_ON + DEAD_CYC);
   localparam int unsigned PW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam logic [PW-1:0] LAST   = PW'(PERIOD - 1);
   localparam logic [PW-1:0] P1_END = PW'(PH_ON);
   localparam logic [PW-1:0] P2_BEG = PW'(PH_ON + DEAD_CYC);
   localparam logic [PW-1:0] P2_END = PW'(2 * PH_ON + DEAD_CYC);

   logic [PW-1:0] pos_q;
   logic [PW-1:0] pos_n;

   always_comb begin
      wrap_n = (pos_q == LAST);
      pos_n  = wrap_n ? '0 : pos_q + PW'(1);
      ctl_n  = wrap_n ? ~ctl_q : ctl_q;
      phi1_n = (pos_n < P1_END);
      phi2_n = (pos_n >= P2_BEG) && (pos_n < P2_END);
   end

   // Reset parks on the last slot, so the first edge after release opens a window.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q  <= LAST;
         ctl_q  <= 1'b0;
         phi1_q <= 1'b0;
         phi2_q <= 1'b0;
      end else begin
         pos_q  <= pos_n;
         ctl_q  <= ctl_n;
         phi1_q <= phi1_n;
         phi2_q <= phi2_n;
      end
   end
endmodule

// File: rtl/dsc_window_arb.sv
module dsc_window_arb
   import dsc_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] cmp_raw,   // {v2_b, v2_a, v1_b, v1_a}
   input  logic       wrap_n,
   input  logic       ctl_n,
   output grant_t     grant_n,
   output grant_t     grant_q
);
   localparam int unsigned N_CMP = 4;

   logic [N_CMP-1:0] cmp_s;

   for (genvar b = 0; b < N_CMP; b++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SYNC_STAGES-2:0], cmp_raw[b]};
      end
      assign cmp_s[b] = chain[SYNC_STAGES-1];
   end

   logic   req1;
   logic   req2;
   grant_t fresh;

   always_comb begin
      req1    = ctl_n ? cmp_s[0] : cmp_s[1];
      req2    = ctl_n ? cmp_s[2] : cmp_s[3];
      fresh   = decide(pri_e'(ctl_n), req1, req2);
      grant_n = wrap_n ? fresh : grant_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) grant_q <= '0;
      else        grant_q <= grant_n;
   end
endmodule

// File: rtl/dsc_gate_drv.sv
module dsc_gate_drv
   import dsc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi1_n,
   input  logic              phi2_n,
   input  grant_t            grant_n,
   output logic [N_RAIL-1:0] ph1_t,
   output logic [N_RAIL-1:0] ph1_i,
   output logic [N_RAIL-1:0] ph2_t,
   output logic [N_RAIL-1:0] ph2_i,
   output logic              sh1,
   output logic              sh2
);
   for (genvar j = 0; j < N_RAIL; j++) begin : g_rail
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ph1_t[j] <= 1'b0;
            ph2_t[j] <= 1'b0;
            ph1_i[j] <= 1'b1;
            ph2_i[j] <= 1'b1;
         end else begin
            ph1_t[j] <= phi1_n & grant_n[j];
            ph2_t[j] <= phi2_n & grant_n[j];
            ph1_i[j] <= ~(phi1_n & grant_n[j]);
            ph2_i[j] <= ~(phi2_n & grant_n[j]);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh1 <= 1'b0;
         sh2 <= 1'b0;
      end else begin
         sh1 <= phi1_n & (|grant_n);
         sh2 <= phi2_n & (|grant_n);
      end
   end
endmodule

// File: rtl/dual_sc_ctrl.sv
module dual_sc_ctrl
   import dsc_pkg::*;
#(
   parameter int unsigned PH_ON       = 3,
   parameter int unsigned DEAD_CYC    = 1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic v1_below_a,
   input  logic v1_below_b,
   input  logic v2_below_a,
   input  logic v2_below_b,
   output logic ctl_o,
   output logic phi1_o,
   output logic phi2_o,
   output logic grant1_o,
   output logic grant2_o,
   output logic o1_ph1,
   output logic o1_ph1_n,
   output logic o1_ph2,
   output logic o1_ph2_n,
   output logic o2_ph1,
   output logic o2_ph1_n,
   output logic o2_ph2,
   output logic o2_ph2_n,
   output logic sh_ph1,
   output logic sh_ph2
);
   if (PH_ON < 1) begin : g_bad_on
      $error("PH_ON must be at least 1");
   end
   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("DEAD_CYC must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic   wrap_n;
   logic   ctl_n;
   logic   phi1_n;
   logic   phi2_n;
   grant_t grant_n;
   grant_t grant_q;
   logic [N_RAIL-1:0] ph1_t;
   logic [N_RAIL-1:0] ph1_i;
   logic [N_RAIL-1:0] ph2_t;
   logic [N_RAIL-1:0] ph2_i;

   dsc_phase_gen #(.PH_ON(PH_ON), .DEAD_CYC(DEAD_CYC)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .wrap_n (wrap_n),
      .ctl_n  (ctl_n),
      .phi1_n (phi1_n),
      .phi2_n (phi2_n),
      .ctl_q  (ctl_o),
      .phi1_q (phi1_o),
      .phi2_q (phi2_o)
   );

   dsc_window_arb #(.SYNC_STAGES(SYNC_STAGES)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmp_raw ({v2_below_b, v2_below_a, v1_below_b, v1_below_a}),
      .wrap_n  (wrap_n),
      .ctl_n   (ctl_n),
      .grant_n (grant_n),
      .grant_q (grant_q)
   );

   dsc_gate_drv u_drv (
      .clk     (clk),
      .rst_n   (rst_n),
      .phi1_n  (phi1_n),
      .phi2_n  (phi2_n),
      .grant_n (grant_n),
      .ph1_t   (ph1_t),
      .ph1_i   (ph1_i),
      .ph2_t   (ph2_t),
      .ph2_i   (ph2_i),
      .sh1     (sh_ph1),
      .sh2     (sh_ph2)
   );

   assign grant1_o = grant_q[RAIL1];
   assign grant2_o = grant_q[RAIL2];
   assign o1_ph1   = ph1_t[RAIL1];
   assign o1_ph1_n = ph1_i[RAIL1];
   assign o1_ph2   = ph2_t[RAIL1];
   assign o1_ph2_n = ph2_i[RAIL1];
   assign o2_ph1   = ph1_t[RAIL2];
   assign o2_ph1_n = ph1_i[RAIL2];
   assign o2_ph2   = ph2_t[RAIL2];
   assign o2_ph2_n = ph2_i[RAIL2];
endmodule

// File: rtl/dual_sc_ctrl_chk.sv
module dual_sc_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic ctl_o,
   input logic phi1_o,
   input logic phi2_o,
   input logic grant1_o,
   input logic grant2_o,
   input logic o1_ph1,
   input logic o1_ph1_n,
   input logic o1_ph2,
   input logic o1_ph2_n,
   input logic o2_ph1,
   input logic o2_ph1_n,
   input logic o2_ph2,
   input logic o2_ph2_n,
   input logic sh_ph1,
   input logic sh_ph2
);
   AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(phi1_o && phi2_o)); // R2
   AST_CTL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phi1_o) |-> (ctl_o != $past(ctl_o))); // R3
   AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(phi1_o) |-> $stable(ctl_o)); // R3
   AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(phi1_o) |-> $stable({grant1_o, grant2_o})); // R4
   AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grant1_o, grant2_o})); // R6
   AST_GATE_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (o1_ph1 == (phi1_o && grant1_o)) && (o1_ph2 == (phi2_o && grant1_o))); // R7
   AST_GATE_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (o2_ph1 == (phi1_o && grant2_o)) && (o2_ph2 == (phi2_o && grant2_o))); // R7
   AST_INV_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (o1_ph1_n != o1_ph1) && (o1_ph2_n != o1_ph2) && (o2_ph1_n != o2_ph1) && (o2_ph2_n != o2_ph2)); // R7
   AST_SHARED_OR: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_ph1 == (o1_ph1 || o2_ph1)) && (sh_ph2 == (o1_ph2 || o2_ph2))); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant1_o && !grant2_o) |-> (!sh_ph1 && !sh_ph2 && !o1_ph1 && !o2_ph2)); // R9
endmodule

bind dual_sc_ctrl dual_sc_ctrl_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctl_o    (ctl_o),
   .phi1_o   (phi1_o),
   .phi2_o   (phi2_o),
   .grant1_o (grant1_o),
   .grant2_o (grant2_o),
   .o1_ph1   (o1_ph1),
   .o1_ph1_n (o1_ph1_n),
   .o1_ph2   (o1_ph2),
   .o1_ph2_n (o1_ph2_n),
   .o2_ph1   (o2_ph1),
   .o2_ph1_n (o2_ph1_n),
   .o2_ph2   (o2_ph2),
   .o2_ph2_n (o2_ph2_n),
   .sh_ph1   (sh_ph1),
   .sh_ph2   (sh_ph2)
);

// File: tb/test_dual_sc_ctrl.sv
module test_dual_sc_ctrl;
   localparam int unsigned PH_ON  = 2;
   localparam int unsigned DEAD   = 2;
   localparam int unsigned SYNC   = 3;
   localparam int unsigned PERIOD = 2 * (PH_ON + DEAD);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic v1a = 1'b0, v1b = 1'b0, v2a = 1'b0, v2b = 1'b0;
   logic ctl_o, phi1_o, phi2_o, grant1_o, grant2_o;
   logic o1_ph1, o1_ph1_n, o1_ph2, o1_ph2_n;
   logic o2_ph1, o2_ph1_n, o2_ph2, o2_ph2_n;
   logic sh_ph1, sh_ph2;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   typedef struct packed {
      logic       c;
      logic [1:0] g;   // bit0 rail 1, bit1 rail 2
   } item_t;
   item_t exp_q[$];
   logic nxt_ctl;

   always #10 clk = ~clk;

   dual_sc_ctrl #(.PH_ON(PH_ON), .DEAD_CYC(DEAD), .SYNC_STAGES(SYNC)) i_dual_sc_ctrl (
      .clk(clk), .rst_n(rst_n),
      .v1_below_a(v1a), .v1_below_b(v1b), .v2_below_a(v2a), .v2_below_b(v2b),
      .ctl_o(ctl_o), .phi1_o(phi1_o), .phi2_o(phi2_o),
      .grant1_o(grant1_o), .grant2_o(grant2_o),
      .o1_ph1(o1_ph1), .o1_ph1_n(o1_ph1_n), .o1_ph2(o1_ph2), .o1_ph2_n(o1_ph2_n),
      .o2_ph1(o2_ph1), .o2_ph1_n(o2_ph1_n), .o2_ph2(o2_ph2), .o2_ph2_n(o2_ph2_n),
      .sh_ph1(sh_ph1), .sh_ph2(sh_ph2)
   );

   task automatic chk(input string rq, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   function automatic logic [1:0] want(input logic c, input logic a1, input logic b1,
                                       input logic a2, input logic b2);
      logic r1, r2;
      r1 = c ? a1 : b1;
      r2 = c ? a2 : b2;
      if (c) return {~r1 & r2, r1};
      else   return {r2, ~r2 & r1};
   endfunction

   // Driver: sets comparators early in a window and queues the next window's result.
   task automatic send(input logic a1, input logic b1, input logic a2, input logic b2,
                       input logic late);
      item_t it;
      @(posedge phi1_o);
      @(negedge clk);
      #2;
      v1a = a1; v1b = b1; v2a = a2; v2b = b2;
      it.c = nxt_ctl;
      it.g = want(nxt_ctl, a1, b1, a2, b2);
      exp_q.push_back(it);
      nxt_ctl = ~nxt_ctl;
      if (late) begin
         // R4: flip everything one cycle before the window opens; must not count
         repeat (PERIOD - 2) @(negedge clk);
         #2;
         v1a = ~a1; v1b = ~b1; v2a = ~a2; v2b = ~b2;
      end
   endtask

   // Monitor: checks each window cycle by cycle.
   initial begin
      item_t it;
      logic [1:0] gw;
      bit have;
      wait (rst_n === 1'b1);
      forever begin
         @(posedge phi1_o);
         have = 1'b0;
         gw = 2'b00;
         for (int i = 0; i < int'(PERIOD); i++) begin
            logic e1, e2;
            @(negedge clk);
            if (i == 0) begin
               gw = {grant2_o, grant1_o};
               if (exp_q.size() > 0) begin
                  it = exp_q.pop_front();
                  have = 1'b1;
                  chk("R3 ctl at window start", int'(ctl_o), int'(it.c));
                  chk("R5 R6 grant pair", int'(gw), int'(it.g));
               end
            end
            e1 = (i < int'(PH_ON));
            e2 = (i >= int'(PH_ON + DEAD)) && (i < int'(2 * PH_ON + DEAD));
            chk("R2 phi1", int'(phi1_o), int'(e1));
            chk("R2 phi2", int'(phi2_o), int'(e2));
            chk("R4 grant held", int'({grant2_o, grant1_o}), int'(gw));
            if (have) chk("R3 ctl held", int'(ctl_o), int'(it.c));
            chk("R7 o1_ph1", int'(o1_ph1), int'(e1 & gw[0]));
            chk("R7 o1_ph2", int'(o1_ph2), int'(e2 & gw[0]));
            chk("R7 o2_ph1", int'(o2_ph1), int'(e1 & gw[1]));
            chk("R7 o2_ph2", int'(o2_ph2), int'(e2 & gw[1]));
            chk("R7 inverted copies", int'({o1_ph1_n, o1_ph2_n, o2_ph1_n, o2_ph2_n}),
                int'(~{e1 & gw[0], e2 & gw[0], e1 & gw[1], e2 & gw[1]} & 4'hF));
            chk("R8 sh_ph1", int'(sh_ph1), int'(e1 & (|gw)));
            chk("R8 sh_ph2", int'(sh_ph2), int'(e2 & (|gw)));
            if (gw == 2'b00)
               chk("R9 idle window quiet", int'({o1_ph1, o1_ph2, o2_ph1, o2_ph2, sh_ph1, sh_ph2}), 0);
         end
      end
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] lf;
      item_t first;
      lf = 8'hA5;
      nxt_ctl = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1 reset true outputs", int'({ctl_o, phi1_o, phi2_o, grant1_o, grant2_o,
          o1_ph1, o1_ph2, o2_ph1, o2_ph2, sh_ph1, sh_ph2}), 0);
      chk("R1 reset inverted outputs", int'({o1_ph1_n, o1_ph2_n, o2_ph1_n, o2_ph2_n}), 15);
      // R1: first window opens with ctl high, phi1 first, nothing requested
      first.c = 1'b1;
      first.g = 2'b00;
      exp_q.push_back(first);
      nxt_ctl = 1'b0;
      rst_n = 1'b1;
      // directed: preference, steal, idle under both priorities
      send(1, 0, 1, 0, 0);  // ctl low next: rail2 b=0, rail1 b=0 -> idle (R9)
      send(1, 0, 1, 0, 0);  // ctl high: rail1 wins (R5)
      send(0, 1, 0, 1, 0);  // ctl low: rail2 wins (R5)
      send(0, 0, 1, 1, 0);  // ctl high: rail1 idle, rail2 steals (R6)
      send(0, 1, 0, 0, 0);  // ctl low: rail2 idle, rail1 steals (R6)
      send(0, 0, 0, 0, 1);  // ctl high: idle, late flip ignored (R4)
      send(1, 1, 1, 1, 1);  // ctl low: rail2 wins, late flip ignored (R4)
      send(1, 1, 0, 0, 0);  // ctl high: rail1 wins
      send(1, 1, 1, 1, 0);  // ctl low: rail2 wins over rail1
      for (int k = 0; k < 40; k++) begin
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         send(lf[0], lf[1], lf[2], lf[3], lf[4] & lf[6]);
      end
      @(posedge phi1_o);
      repeat (2 * PERIOD + 2) @(negedge clk);
      chk("R3 all windows consumed", exp_q.size(), 0);
      finish_run();
   end
endmodule